// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block sits on the controller side of a DDR2 command bus. It watches the chip-select, row strobe, column strobe and write-enable levels together with the bank and address buses. On every rising clock edge it captures them and decodes the command. It tracks the state of each of the four banks as idle, active with an open row, or closing under auto-precharge. From that state it judges whether the command it just captured is legal.

Each cycle it reports the decoded command, the bank it targets and an illegal-command flag. It also reports the open-bank mask, the row held open in the targeted bank, and an all-idle flag. Power-down and self-refresh logic uses the all-idle flag as its entry permission. Two timers per bank hold back too-early accesses. The activate-to-column delay (TRCD) and the precharge-to-activate delay (TRP) default to 5 clocks, which is 12.5 ns at 400 MHz. A column access with address bit 10 high closes its bank by itself after a burst window of AP_CYC clocks.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: With cs_n sampled high, the command is a no-operation (cmd_o = 0) whatever the other pins are, and no bank state changes.
- R2: Pins are captured on a rising edge, and cmd_o, bank_o and illegal_o describe them from that edge until the next. With cs_n low and {ras_n,cas_n,we_n} given as bits: 111 gives NOP = 0, 011 gives ACT = 1, 010 gives PRE = 2, 101 gives RD = 3, and 100 gives WR = 4. The codes 00x and 110 give OTHER = 5. bank_o is the captured bank address.
- R3: A legal ACT makes its bank active from the next cycle on. From then, while bank_o selects that bank, row_o shows the captured 13-bit address.
- R4: PRE with addr[10] low makes the selected bank idle from the next cycle and leaves the other banks alone. PRE to an idle bank is legal and has no effect.
- R5: PRE with addr[10] high makes every bank idle from the next cycle, whatever the bank address is.
- R6: RD or WR is legal only to an active bank that is not closing, and only at least TRCD cycles after that bank's ACT appeared on cmd_o. Otherwise illegal_o is high and no bank state changes.
- R7: ACT is illegal to a bank that is active or closing. It is also illegal earlier than TRP cycles after the cycle in which that bank was precharged. An illegal ACT changes neither the bank state nor its row.
- R8: A legal RD or WR with addr[10] high keeps its bank active for AP_CYC cycles after the command cycle, and the bank reads idle from cycle AP_CYC+1 on. While the bank is closing, RD, WR and ACT to it are illegal, and a PRE closes it at once. After the automatic close, ACT becomes legal TRP-1 cycles after the bank first reads idle.
- R9: OTHER (refresh, mode set, self-refresh entry) is legal only while every bank is idle; otherwise illegal_o is high.
- R10: bank_act_o bit n is high while bank n is active or closing, and all_idle_o is high exactly when no bit is set. After reset every bank is idle and cmd_o is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address at ACT; bit 10 is the auto-precharge / all-banks flag |
| cmd_o | output | 3 | Decoded command code (see R2) |
| bank_o | output | 2 | Bank targeted by the captured command |
| illegal_o | output | 1 | Captured command is illegal in the current bank state |
| all_idle_o | output | 1 | No bank is open; power-down and self-refresh may be entered |
| bank_act_o | output | 4 | Per-bank open flags |
| row_o | output | 13 | Row last opened in the bank selected by bank_o |

## Verification
The interesting collisions happen when an auto-precharge countdown expires in the same cycle as an explicit command to the same bank or to all banks. The bench sets this up with a write carrying addr[10] high. Exactly AP_CYC cycles later it issues either a single-bank PRE, an ACT, or an all-bank PRE. The cycle-accurate reference model then judges whether the ACT is still refused and whether the bank starts its TRP wait from a single close. A second collision pairs an illegal column access against a bank that is still in its TRCD wait while another bank is closing; the bench checks that neither bank's state is disturbed.

// File: rtl/ddr2_cmd_tracker.sv
`timescale 1ns/1ps
module ddr2_cmd_tracker #(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int AP_BIT = 10,
  parameter int TRCD   = 5,
  parameter int TRP    = 5,
  parameter int AP_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [BA_W-1:0]    ba,
  input  logic [ROW_W-1:0]   addr,
  output logic [2:0]         cmd_o,
  output logic [BA_W-1:0]    bank_o,
  output logic               illegal_o,
  output logic               all_idle_o,
  output logic [(1<<BA_W)-1:0] bank_act_o,
  output logic [ROW_W-1:0]   row_o
);
  localparam int NBANK = 1 << BA_W;
  localparam int TMAX  = (TRCD > TRP) ? ((TRCD > AP_CYC) ? TRCD : AP_CYC)
                                      : ((TRP > AP_CYC) ? TRP : AP_CYC);
  localparam int TW    = $clog2(TMAX + 1);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2,
                         C_RD  = 3'd3, C_WR  = 3'd4, C_OTH = 3'd5;
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1, S_CLOSE = 2'd2;

  logic             cs_q, ras_q, cas_q, we_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 1'b1; ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      ba_q <= '0;   addr_q <= '0;
    end else begin
      cs_q <= cs_n; ras_q <= ras_n; cas_q <= cas_n; we_q <= we_n;
      ba_q <= ba;   addr_q <= addr;
    end

  logic [2:0] cmd;
  always_comb begin
    if (cs_q) cmd = C_NOP;
    else case ({ras_q, cas_q, we_q})
      3'b111:  cmd = C_NOP;
      3'b011:  cmd = C_ACT;
      3'b010:  cmd = C_PRE;
      3'b101:  cmd = C_RD;
      3'b100:  cmd = C_WR;
      default: cmd = C_OTH;
    endcase
  end

  wire ap  = addr_q[AP_BIT];
  wire col = (cmd == C_RD) || (cmd == C_WR);

  logic [NBANK-1:0][1:0]       st_v;
  logic [NBANK-1:0][TW-1:0]    tmr_v;
  logic [NBANK-1:0][ROW_W-1:0] row_v;

  wire [1:0]    tgt_st  = st_v[ba_q];
  wire          tgt_rdy = (tmr_v[ba_q] == '0);
  logic         illegal;

  always_comb begin
    illegal = 1'b0;
    if (cmd == C_ACT)      illegal = !(tgt_st == S_IDLE && tgt_rdy);
    else if (col)          illegal = !(tgt_st == S_OPEN && tgt_rdy);
    else if (cmd == C_OTH) illegal = !all_idle_o;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [1:0]       st;
    logic [TW-1:0]    tmr;
    logic [ROW_W-1:0] row;
    wire sel = (ba_q == BA_W'(g));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st <= S_IDLE; tmr <= '0; row <= '0;
      end else if (cmd == C_PRE && (sel || ap) && st != S_IDLE) begin
        st <= S_IDLE; tmr <= TW'(TRP - 1);
      end else if (cmd == C_ACT && sel && !illegal) begin
        st <= S_OPEN; tmr <= TW'(TRCD - 1); row <= addr_q;
      end else if (col && sel && !illegal && ap) begin
        st <= S_CLOSE; tmr <= TW'(AP_CYC - 1);
      end else if (st == S_CLOSE && tmr == '0) begin
        st <= S_IDLE; tmr <= TW'(TRP - 1);
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end

    assign st_v[g]       = st;
    assign tmr_v[g]      = tmr;
    assign row_v[g]      = row;
    assign bank_act_o[g] = (st != S_IDLE);
  end

  assign cmd_o      = cmd;
  assign bank_o     = ba_q;
  assign illegal_o  = illegal;
  assign all_idle_o = ~|bank_act_o;
  assign row_o      = row_v[ba_q];
endmodule

module ddr2_cmd_tracker_chk #(parameter int BA_W = 2) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  ap_q,
  input logic [2:0]            cmd_o,
  input logic [BA_W-1:0]       bank_o,
  input logic                  illegal_o,
  input logic                  all_idle_o,
  input logic [(1<<BA_W)-1:0]  bank_act_o
);
  // R1
  cs_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> cmd_o == 3'd0);
  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd1 && !illegal_o) |=> bank_act_o[$past(bank_o)]);
  // R5
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd2 && ap_q) |=> all_idle_o);
  // R6
  col_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == 3'd3 || cmd_o == 3'd4) && !bank_act_o[bank_o]) |-> illegal_o);
  // R9
  other_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd5 && !all_idle_o) |-> illegal_o);
  // R7
  act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd1 && bank_act_o[bank_o]) |-> illegal_o);
endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ap_q(addr_q[AP_BIT]),
  .cmd_o(cmd_o), .bank_o(bank_o), .illegal_o(illegal_o),
  .all_idle_o(all_idle_o), .bank_act_o(bank_act_o));

// File: tb/sim_ddr2_cmd_tracker.sv
`timescale 1ns/1ps
module sim_ddr2_cmd_tracker;
  localparam int TRCD = 5, TRP = 5, AP_CYC = 4;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [12:0] addr = 0;
  logic [2:0] cmd_o;
  logic [1:0] bank_o;
  logic illegal_o, all_idle_o;
  logic [3:0] bank_act_o;
  logic [12:0] row_o;

  always #10 clk = ~clk;

  ddr2_cmd_tracker u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .bank_o(bank_o), .illegal_o(illegal_o), .all_idle_o(all_idle_o),
    .bank_act_o(bank_act_o), .row_o(row_o));

  int vectors = 0, errors = 0;
  int mst[4], mtmr[4], mrow[4];
  logic p_cs = 1, p_ras = 1, p_cas = 1, p_we = 1;
  int p_ba = 0;
  logic [12:0] p_addr = 0;

  function automatic int dec();
    if (p_cs) return 0;
    if (p_ras && p_cas && p_we) return 0;
    if (!p_ras && p_cas && p_we) return 1;
    if (!p_ras && p_cas && !p_we) return 2;
    if (p_ras && !p_cas && p_we) return 3;
    if (p_ras && !p_cas && !p_we) return 4;
    return 5;
  endfunction

  function automatic bit exp_ill();
    int c = dec();
    bit busy = 0;
    for (int i = 0; i < 4; i++) if (mst[i] != 0) busy = 1;
    if (c == 1) return !(mst[p_ba] == 0 && mtmr[p_ba] == 0);
    if (c == 3 || c == 4) return !(mst[p_ba] == 1 && mtmr[p_ba] == 0);
    if (c == 5) return busy;
    return 0;
  endfunction

  task automatic model_edge();
    int c = dec();
    bit il = exp_ill();
    for (int i = 0; i < 4; i++) begin
      bit sel = (p_ba == i);
      if (c == 2 && (sel || p_addr[10]) && mst[i] != 0) begin
        mst[i] = 0; mtmr[i] = TRP - 1;
      end else if (c == 1 && sel && !il) begin
        mst[i] = 1; mtmr[i] = TRCD - 1; mrow[i] = int'(p_addr);
      end else if ((c == 3 || c == 4) && sel && !il && p_addr[10]) begin
        mst[i] = 2; mtmr[i] = AP_CYC - 1;
      end else if (mst[i] == 2 && mtmr[i] == 0) begin
        mst[i] = 0; mtmr[i] = TRP - 1;
      end else if (mtmr[i] > 0) mtmr[i]--;
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int open = 0;
    for (int i = 0; i < 4; i++) if (mst[i] != 0) open |= (1 << i);
    chk({tag, "/R2"}, "cmd_o", int'(cmd_o), dec());
    chk({tag, "/R2"}, "bank_o", int'(bank_o), p_ba);
    chk(tag, "illegal_o", int'(illegal_o), int'(exp_ill()));
    chk({tag, "/R10"}, "bank_act_o", int'(bank_act_o), open);
    chk({tag, "/R10"}, "all_idle_o", int'(all_idle_o), int'(open == 0));
    chk({tag, "/R3"}, "row_o", int'(row_o), mrow[p_ba]);
  endtask

  // drive at negedge, model advances at posedge, compare mid-cycle
  task automatic step(string tag, logic c, logic r, logic ca, logic w, int b, logic [12:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b[1:0]; addr = a;
    @(posedge clk);
    model_edge();
    p_cs = c; p_ras = r; p_cas = ca; p_we = w; p_ba = b; p_addr = a;
    #5 compare(tag);
    @(negedge clk);
  endtask

  task automatic nop(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, 1, 1, 1, 1, 0, 0);
  endtask
  task automatic act(string tag, int b, logic [12:0] row); step(tag, 0, 0, 1, 1, b, row); endtask
  task automatic pre(string tag, int b, bit all); step(tag, 0, 0, 1, 0, b, all ? 13'h0400 : 13'h0); endtask
  task automatic rd(string tag, int b, bit ap); step(tag, 0, 1, 0, 1, b, ap ? 13'h0400 : 13'h0); endtask
  task automatic wr(string tag, int b, bit ap); step(tag, 0, 1, 0, 0, b, ap ? 13'h0400 : 13'h0); endtask
  task automatic oth(string tag); step(tag, 0, 0, 0, 1, 0, 0); endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtmr[i] = 0; mrow[i] = 0; end
    repeat (3) @(negedge clk);
    #5 compare("R10_reset");
    rst_n = 1;
    @(negedge clk);
    nop("R10_reset", 2);
    // R1: activate pattern masked by cs_n high
    step("R1", 1, 0, 1, 1, 2, 13'h0155);
    step("R1", 1, 1, 0, 0, 1, 13'h0400);
    nop("R1", 1);
    // R3 / R6: open bank 0, column access too early then on time
    act("R3", 0, 13'h1ABC);
    rd("R6", 0, 0);
    nop("R6", 2);
    rd("R6", 0, 0);
    wr("R6", 0, 0);
    // R7: activate to an open bank
    act("R7", 0, 13'h0011);
    // R6: read to idle bank
    rd("R6", 3, 0);
    // R9: refresh while a bank is open
    oth("R9");
    // R4: precharge idle bank 2, then bank 0, then early activate
    pre("R4", 2, 0);
    pre("R4", 0, 0);
    act("R7", 0, 13'h0222);
    nop("R7", 2);
    act("R7", 0, 13'h0333);
    // R5: open banks 1 and 2, precharge all with bank address 3
    act("R5", 1, 13'h0ABC);
    act("R5", 2, 13'h1555);
    nop("R5", 5);
    pre("R5", 3, 1);
    nop("R5", 5);
    oth("R9");
    // R8: write with auto-precharge, closing bank refuses access
    act("R8", 1, 13'h0777);
    nop("R8", 4);
    wr("R8", 1, 1);
    rd("R8", 1, 0);
    act("R8", 1, 13'h0001);
    nop("R8", 1);
    act("R8", 1, 13'h0002);  // expiry cycle: still refused
    nop("R8", 3);
    act("R8", 1, 13'h0003);
    nop("R8", 6);
    // collision: single PRE on the expiry cycle
    act("R8", 2, 13'h0444);
    nop("R8", 4);
    rd("R8", 2, 1);
    act("R8", 3, 13'h0999);
    wr("R6", 3, 0);          // bank 3 still in TRCD wait
    nop("R8", 1);
    pre("R4", 2, 0);         // bank 2 expiry cycle
    nop("R8", 4);
    act("R7", 2, 13'h0888);
    nop("R8", 4);
    // collision: PRE-all on expiry cycle of bank 2
    rd("R8", 2, 1);
    nop("R8", 3);
    pre("R5", 0, 1);
    nop("R5", 5);
    // R2: other encodings
    step("R2", 0, 1, 1, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1, 0);
    step("R2", 0, 1, 1, 1, 2, 0);
    nop("R2", 2);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule